// File: doc/BRIEF.md
# Buck Converter Startup Sequencer

This block orders the power-up of a step-down converter controller. It stays idle until the supply monitor reports that the supply is above the lockout level. It then opens a programming window in which the overcurrent limit is set up. At the end of that window a sample-and-hold strobe captures the limit value. The window ends early if the sensed programming voltage reaches its clamp level. In that case the limit is taken as the maximum and a clamp flag is raised.

After the window, a digital reference code climbs in equal steps from zero to a full-scale code. This code drives the external reference DAC for soft-start. The low-side switch stays disabled during the climb until the high-side switch has been seen switching. This protects a pre-biased output. If the high side never starts, because the output already sits above target, the low side is released once the ramp completes. Soft-start done is raised when the code reaches full scale.

An overcurrent fault after the window latches the block off. Only a loss of supply clears it. A disable request returns the block to idle, and releasing the request restarts the whole sequence.

Top module: `startup_seq`

## Requirements
- R1: After reset, and for as long as `uvlo_ok` is low, every output is zero. The sequence starts in the first cycle with `uvlo_ok` high and `dis_req` low.
- R2: The limit-programming window lasts exactly OCSET_CYC cycles. `sh_strobe` is a single-cycle pulse in the first cycle after the window. `ref_code` is zero throughout the window.
- R3: If `clamp_hit` is high during the window, the window ends at that edge. `sh_strobe` pulses next, and `clamp_flag` goes high and stays high until the block returns to idle or programming.
- R4: During the ramp, `ref_code` starts at 0 and rises by RAMP_STEP after every STEP_CYC cycles. The final step saturates at REF_FULL.
- R5: During the ramp, `ls_en` is low until the cycle after `hs_started` is first sampled high. From then on it stays high. `ls_en` is low while idle, programming or latched off.
- R6: If `hs_started` is never seen during the ramp, `ls_en` goes high in the same cycle that `ss_done` rises.
- R7: `ss_done` rises in the same cycle that `ref_code` reaches REF_FULL. Both then hold.
- R8: `oc_fault` sampled high during the ramp or after it latches the block off. In that state `ref_code`, `ls_en` and `ss_done` are zero, and `dis_req` has no effect. This holds while `uvlo_ok` stays high.
- R9: `dis_req` sampled high (when not latched off) returns the block to idle with outputs zero. Releasing it restarts from the programming window.
- R10: `uvlo_ok` sampled low returns the block to idle from any state, including latched off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_ok | input | 1 | Supply above lockout level (hysteresis applied upstream) |
| dis_req | input | 1 | Disable request |
| hs_started | input | 1 | High-side switch has begun switching |
| oc_fault | input | 1 | Overcurrent detected |
| clamp_hit | input | 1 | Programming voltage reached its clamp level |
| ref_code | output | REF_W | Soft-start reference code for the DAC |
| sh_strobe | output | 1 | Capture pulse for the overcurrent limit |
| clamp_flag | output | 1 | Limit forced to maximum by the clamp |
| ls_en | output | 1 | Low-side driver enable |
| ss_done | output | 1 | Soft-start complete |

## Verification
The bench aims at the following corner cases, and what a faulty design would do in each:

- **Last ramp step.** The step size does not divide full scale. A design that adds without saturating would overshoot the code. It would also never raise done.
- **Pre-biased startup.** In this run `hs_started` never arrives. A wrong design would either keep the low side off after the ramp, or enable it from the first ramp cycle.
- **Clamp early exit.** A faulty design would run the full window regardless, or drop the clamp flag during the ramp.
- **Latched-off state.** The bench toggles disable inside the latched state. Any path that lets disable clear the latch would show a restarted programming window and a strobe.

// File: rtl/startup_pkg.sv
package startup_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OCSET = 3'd1,
    ST_RAMP  = 3'd2,
    ST_DONE  = 3'd3,
    ST_OFF   = 3'd4
  } seq_state_t;
endpackage

// File: rtl/startup_timer.sv
module startup_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] cnt_q
);
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ref_ramp.sv
module ref_ramp #(
  parameter int REF_W     = 8,
  parameter int REF_FULL  = 200,
  parameter int RAMP_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step_en,
  output logic [REF_W-1:0] ref_q,
  output logic             hit
);
  localparam int SW = REF_W + 1;
  logic [SW-1:0]    sum;
  logic             reach;
  logic [REF_W-1:0] ref_d;

  always_comb begin
    sum   = {1'b0, ref_q} + SW'(RAMP_STEP);
    reach = (sum >= SW'(REF_FULL));
    hit   = step_en && reach;
    ref_d = ref_q;
    if (clr)          ref_d = '0;
    else if (step_en) ref_d = reach ? REF_W'(REF_FULL) : sum[REF_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_d;
  end

  // R4: code never passes full scale
  a_r4_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
    ref_q <= REF_W'(REF_FULL));
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_pkg::*;
#(
  parameter int REF_W     = 8,
  parameter int REF_FULL  = 200,
  parameter int RAMP_STEP = 8,
  parameter int STEP_CYC  = 4,
  parameter int OCSET_CYC = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uvlo_ok,
  input  logic             dis_req,
  input  logic             hs_started,
  input  logic             oc_fault,
  input  logic             clamp_hit,
  output logic [REF_W-1:0] ref_code,
  output logic             sh_strobe,
  output logic             clamp_flag,
  output logic             ls_en,
  output logic             ss_done
);
  localparam int TMAX = (OCSET_CYC > STEP_CYC) ? OCSET_CYC : STEP_CYC;
  localparam int CW   = $clog2(TMAX + 1);

  seq_state_t    st_q, st_d;
  logic [CW-1:0] cnt;
  logic          tick, win_last, ramp_hit;
  logic          tmr_clr, tmr_en, ref_clr;
  logic          hs_q, hs_d, clamp_q, clamp_d, strobe_q, strobe_d;

  assign tick     = (st_q == ST_RAMP)  && (cnt == CW'(STEP_CYC - 1));
  assign win_last = (st_q == ST_OCSET) && (cnt == CW'(OCSET_CYC - 1));

  always_comb begin
    st_d = st_q;
    if (!uvlo_ok)                                             st_d = ST_IDLE;
    else if (st_q == ST_OFF)                                  st_d = ST_OFF;
    else if (dis_req)                                         st_d = ST_IDLE;
    else if ((st_q == ST_RAMP || st_q == ST_DONE) && oc_fault) st_d = ST_OFF;
    else begin
      case (st_q)
        ST_IDLE:  st_d = ST_OCSET;
        ST_OCSET: if (win_last || clamp_hit) st_d = ST_RAMP;
        ST_RAMP:  if (ramp_hit) st_d = ST_DONE;
        ST_DONE:  st_d = ST_DONE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tmr_clr  = (st_d != st_q) || tick;
    tmr_en   = (st_q == ST_OCSET) || (st_q == ST_RAMP);
    ref_clr  = (st_d == ST_IDLE) || (st_d == ST_OCSET) || (st_d == ST_OFF);
    strobe_d = (st_q == ST_OCSET) && (st_d == ST_RAMP);
    if (st_d == ST_IDLE || st_d == ST_OCSET) clamp_d = 1'b0;
    else clamp_d = clamp_q | ((st_q == ST_OCSET) && clamp_hit);
    if (st_d == ST_RAMP) hs_d = hs_q | ((st_q == ST_RAMP) && hs_started);
    else                 hs_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      hs_q     <= 1'b0;
      clamp_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      hs_q     <= hs_d;
      clamp_q  <= clamp_d;
      strobe_q <= strobe_d;
    end
  end

  startup_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en), .cnt_q(cnt)
  );

  ref_ramp #(.REF_W(REF_W), .REF_FULL(REF_FULL), .RAMP_STEP(RAMP_STEP)) u_ramp (
    .clk(clk), .rst_n(rst_n), .clr(ref_clr), .step_en(tick),
    .ref_q(ref_code), .hit(ramp_hit)
  );

  assign sh_strobe  = strobe_q;
  assign clamp_flag = clamp_q;
  assign ss_done    = (st_q == ST_DONE);
  assign ls_en      = (st_q == ST_DONE) || ((st_q == ST_RAMP) && hs_q);

  // R2: capture strobe is a single-cycle pulse
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    sh_strobe |=> !sh_strobe);
  // R7: done only at full scale
  a_r7_done_full: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> (ref_code == REF_W'(REF_FULL)));
  // R4: code never falls while ramping
  a_r4_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RAMP) |=> ((st_q != ST_RAMP) || (ref_code >= $past(ref_code))));
  // R8: latched off survives anything but supply loss
  a_r8_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_OFF) && uvlo_ok) |=> (st_q == ST_OFF));
  // R5: low side held off outside the ramp and run states
  a_r5_ls_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE || st_q == ST_OCSET || st_q == ST_OFF) |-> !ls_en);
  // R10: supply loss always leads to idle outputs
  a_r10_uvlo_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !uvlo_ok |=> (!ss_done && !ls_en && ref_code == '0));
endmodule

// File: tb/sim_startup_seq.sv
module sim_startup_seq;
  localparam int CLK_PER   = 10;
  localparam int REF_W     = 8;
  localparam int REF_FULL  = 200;
  localparam int RAMP_STEP = 7;
  localparam int STEP_CYC  = 4;
  localparam int OCSET_CYC = 50;
  localparam int M_IDLE = 0, M_OCSET = 1, M_RAMP = 2, M_DONE = 3, M_OFF = 4;

  logic clk, rst_n, uvlo_ok, dis_req, hs_started, oc_fault, clamp_hit;
  logic [REF_W-1:0] ref_code;
  logic sh_strobe, clamp_flag, ls_en, ss_done;
  int vectors, errors, cyc;
  int m_st, m_cnt, m_ref;
  bit m_hs, m_clamp, m_strobe;

  startup_seq #(.REF_W(REF_W), .REF_FULL(REF_FULL), .RAMP_STEP(RAMP_STEP),
                .STEP_CYC(STEP_CYC), .OCSET_CYC(OCSET_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .dis_req(dis_req),
    .hs_started(hs_started), .oc_fault(oc_fault), .clamp_hit(clamp_hit),
    .ref_code(ref_code), .sh_strobe(sh_strobe), .clamp_flag(clamp_flag),
    .ls_en(ls_en), .ss_done(ss_done));

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  function automatic int next_ref(int r);
    return (r + RAMP_STEP >= REF_FULL) ? REF_FULL : r + RAMP_STEP;
  endfunction

  // expected behaviour from the requirements, one step per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_IDLE; m_cnt = 0; m_ref = 0; m_hs = 0; m_clamp = 0; m_strobe = 0;
    end else begin
      int nst; bit tk, last;
      tk   = (m_st == M_RAMP)  && (m_cnt == STEP_CYC - 1);
      last = (m_st == M_OCSET) && (m_cnt == OCSET_CYC - 1);
      if (!uvlo_ok) nst = M_IDLE;
      else if (m_st == M_OFF) nst = M_OFF;
      else if (dis_req) nst = M_IDLE;
      else if ((m_st == M_RAMP || m_st == M_DONE) && oc_fault) nst = M_OFF;
      else if (m_st == M_IDLE) nst = M_OCSET;
      else if (m_st == M_OCSET) nst = (last || clamp_hit) ? M_RAMP : M_OCSET;
      else if (m_st == M_RAMP) nst = (tk && next_ref(m_ref) == REF_FULL) ? M_DONE : M_RAMP;
      else nst = m_st;
      m_strobe = (m_st == M_OCSET) && (nst == M_RAMP);
      if (nst == M_IDLE || nst == M_OCSET) m_clamp = 0;
      else m_clamp = m_clamp | ((m_st == M_OCSET) && clamp_hit);
      if (nst == M_RAMP) m_hs = m_hs | ((m_st == M_RAMP) && hs_started);
      else m_hs = 0;
      if (nst == M_IDLE || nst == M_OCSET || nst == M_OFF) m_ref = 0;
      else if (tk) m_ref = next_ref(m_ref);
      if (nst != m_st || tk) m_cnt = 0;
      else if (m_st == M_OCSET || m_st == M_RAMP) m_cnt = m_cnt + 1;
      m_st = nst;
    end
  end

  task automatic cmp(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    int mls;
    mls = (m_st == M_DONE || (m_st == M_RAMP && m_hs)) ? 1 : 0;
    cmp(int'(ref_code) == m_ref, "R4 ref_code", int'(ref_code), m_ref);
    cmp(sh_strobe == m_strobe, "R2 sh_strobe", sh_strobe, m_strobe);
    cmp(clamp_flag == m_clamp, "R3 clamp_flag", clamp_flag, m_clamp);
    cmp(int'(ls_en) == mls, "R5 ls_en", ls_en, mls);
    cmp(ss_done == (m_st == M_DONE), "R7 ss_done", ss_done, int'(m_st == M_DONE));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  initial begin
    int first_strobe, waited;
    void'($urandom(32'd4711));
    vectors = 0; errors = 0; cyc = 0;
    rst_n = 0; uvlo_ok = 0; dis_req = 0; hs_started = 0; oc_fault = 0; clamp_hit = 0;
    #(3*CLK_PER) @(negedge clk);
    cmp(ref_code == 0 && !ls_en && !ss_done && !sh_strobe && !clamp_flag,
        "R1 reset outputs", int'(ref_code), 0);
    rst_n = 1;
    run(10);
    cmp(ref_code == 0 && !ls_en && !ss_done, "R1 held while uvlo low", int'(ls_en), 0);

    // full window then pre-biased ramp: hs never starts
    uvlo_ok = 1;
    first_strobe = 0;
    for (int i = 1; i <= OCSET_CYC + 3; i++) begin
      @(negedge clk); check_all();
      if (sh_strobe && first_strobe == 0) first_strobe = i;
    end
    cmp(first_strobe == OCSET_CYC + 1, "R2 window length", first_strobe, OCSET_CYC + 1);
    waited = 0;
    while (!ss_done && waited < 1000) begin
      @(negedge clk); check_all(); waited++;
      if (!ss_done) cmp(!ls_en, "R5 ls held off before hs", ls_en, 0);
    end
    cmp(ls_en == 1'b1, "R6 pre-bias ls at done", ls_en, 1);
    cmp(int'(ref_code) == REF_FULL, "R7 full scale at done", int'(ref_code), REF_FULL);

    // overcurrent latch, disable must not clear it
    oc_fault = 1; run(1); oc_fault = 0;
    run(3); dis_req = 1; run(4); dis_req = 0; run(OCSET_CYC + 10);
    cmp(ref_code == 0 && !ls_en && !ss_done && !sh_strobe, "R8 latched off ignores disable",
        int'(ss_done), 0);
    // supply loss clears latch
    uvlo_ok = 0; run(3);
    cmp(!ls_en && ref_code == 0, "R10 supply loss idle", int'(ls_en), 0);
    uvlo_ok = 1;

    // clamp early exit
    run(10); clamp_hit = 1; run(1); clamp_hit = 0; run(2);
    cmp(clamp_flag == 1'b1, "R3 clamp flag after early exit", clamp_flag, 1);
    // hs seen mid-ramp
    run(20); hs_started = 1; run(1); hs_started = 0; run(1);
    cmp(ls_en == 1'b1, "R5 ls after hs seen", ls_en, 1);
    // disable mid-ramp and restart
    dis_req = 1; run(2);
    cmp(ref_code == 0 && !ls_en, "R9 disable to idle", int'(ref_code), 0);
    dis_req = 0; run(OCSET_CYC + 5);

    // random phase
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk); check_all();
      uvlo_ok    = ($urandom_range(0, 599) != 0);
      dis_req    = ($urandom_range(0, 399) == 0);
      oc_fault   = ($urandom_range(0, 899) == 0);
      clamp_hit  = ($urandom_range(0, 199) == 0);
      hs_started = ($urandom_range(0, 59) == 0);
    end
    summary();
  end
endmodule